// File: doc/BRIEF.md
# Video line number and CRC inserter

This block sits on one 10-bit component stream of a high-definition serial video link, either the luma stream or the time-multiplexed chroma stream, and runs at one word per clock. It watches the stream for the four-word timing sequence that ends the active picture of each line. It then fills the four word slots that follow that sequence with a two-word binary line number and a two-word checksum over the line. Luma and chroma each get their own instance, so each stream carries its own independent checksum.

The upstream source supplies the timing sequences and leaves four placeholder words after each end-of-active sequence; this block overwrites those placeholders in place, so the word rate and line length are unchanged. The line number comes in on a side input and is captured when the end-of-active status word arrives. Each word leaves the block one clock after it enters, and a flag marks the four overwritten words.

Top module: `vid_lnum_crc_ins`

## Requirements
- R1: While reset is asserted and before any valid input, `dout`, `dout_valid` and `ins_flag` are all 0.
- R2: Every input word appears at the output exactly one clock later; `dout_valid` is `din_valid` delayed by one clock, and `ins_flag` is 0 whenever `dout_valid` is 0. Cycles with `din_valid` low are skipped by all sequence tracking.
- R3: Every valid word outside the four insertion slots leaves the block unchanged.
- R4: A timing sequence is four consecutive valid words 0x3FF, 0x000, 0x000 and a status word; it is an end-of-active code when bit 6 of the status word is 1 and a start-of-active code when bit 6 is 0. Only end-of-active codes trigger insertion, and a broken preamble triggers nothing.
- R5: The four valid words following the end-of-active status word are replaced, in order, by line word 0, line word 1, checksum word 0 and checksum word 1, each output with `ins_flag` = 1.
- R6: For the 11-bit line number L sampled on `line_num` in the cycle the end-of-active status word is accepted, line word 0 is {~L[6], L[6:0], 2'b00} and line word 1 is {1'b1, 3'b000, L[10:7], 2'b00}; later changes of `line_num` do not affect them.
- R7: The checksum is an 18-bit register C starting at 0. Each word is fed least significant bit first; per bit b: f = C[0] ^ b, C = C >> 1, and if f then C ^= 0x23000 (the polynomial x^18 + x^5 + x^4 + 1 in reflected form). Checksum word 0 is {~C[8], C[8:0]} and word 1 is {~C[17], C[17:9]}.
- R8: The checksum covers every valid word from the one after a start-of-active status word through line word 1 inclusive (active picture, the end-of-active sequence and both line words); it returns to 0 after checksum word 1 is output, and words between then and the next start-of-active code are excluded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_valid | input | 1 | Input word strobe |
| din | input | 10 | Input component word |
| line_num | input | 11 | Current line number, binary |
| dout_valid | output | 1 | Output word strobe |
| dout | output | 10 | Reformatted component word |
| ins_flag | output | 1 | High on the four overwritten words |

## Verification
A corrupted checksum register or coverage window shows up only at the two checksum slots of the next line, so the bench repeats an identical line after unrelated traffic and compares both checksum pairs, which exposes any leakage from the blanking interval or a missed clear within one line. A slot sequencer that drifts shows at the very next word as a flagged pass-through word or a missing flag. A wrong preamble match either inserts into a line that should pass untouched or skips insertion, visible four words after the status word.

// File: rtl/vid_lnum_crc_pkg.sv
package vid_lnum_crc_pkg;

  localparam int unsigned WORD_W  = 10;
  localparam int unsigned LINE_W  = 11;
  localparam int unsigned CRC_W   = 18;
  localparam int unsigned PRE_LEN = 3;
  localparam int unsigned H_BIT   = 6;
  localparam logic [CRC_W-1:0] CRC_MASK = 18'h23000;
  localparam logic [WORD_W-1:0] WORD_ONES = '1;
  localparam logic [WORD_W-1:0] WORD_ZERO = '0;

  typedef enum logic [2:0] {
    SLOT_NONE = 3'd0,
    SLOT_LN0  = 3'd1,
    SLOT_LN1  = 3'd2,
    SLOT_CRC0 = 3'd3,
    SLOT_CRC1 = 3'd4
  } slot_e;

  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                input logic [WORD_W-1:0] w);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < WORD_W; i++) begin
      fb = r[0] ^ w[i];
      r  = r >> 1;
      if (fb) r = r ^ CRC_MASK;
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] line_word_lo(input logic [LINE_W-1:0] ln);
    return {~ln[6], ln[6:0], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] line_word_hi(input logic [LINE_W-1:0] ln);
    return {1'b1, 3'b000, ln[10:7], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] crc_word_lo(input logic [CRC_W-1:0] c);
    return {~c[8], c[8:0]};
  endfunction

  function automatic logic [WORD_W-1:0] crc_word_hi(input logic [CRC_W-1:0] c);
    return {~c[17], c[17:9]};
  endfunction

endpackage

// File: rtl/vid_lnum_crc_trs_watch.sv
module vid_lnum_crc_trs_watch
  import vid_lnum_crc_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned NPRE = PRE_LEN,
  parameter int unsigned HPOS = H_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic [W-1:0] word,
  output logic         eav_hit,
  output logic         sav_hit
);

  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] hist_q [NPRE];
  logic [NPRE-1:0] match;

  // hist_q[0] is the oldest word; it must be all ones, the rest all zeros
  genvar g;
  generate
    for (g = 0; g < NPRE; g++) begin : g_match
      if (g == 0) begin : g_first
        assign match[g] = (hist_q[g] == ONES);
      end else begin : g_rest
        assign match[g] = (hist_q[g] == ZERO);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPRE; i++) hist_q[i] <= ZERO;
    end else if (valid) begin
      for (int i = 0; i < NPRE - 1; i++) hist_q[i] <= hist_q[i+1];
      hist_q[NPRE-1] <= word;
    end
  end

  logic pre_ok;
  assign pre_ok  = valid && (&match);
  assign eav_hit = pre_ok && word[HPOS];
  assign sav_hit = pre_ok && !word[HPOS];

endmodule

// File: rtl/vid_lnum_crc_acc.sv
module vid_lnum_crc_acc
  import vid_lnum_crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              clear,
  input  logic [WORD_W-1:0] word,
  output logic [CRC_W-1:0]  crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc <= '0;
    else if (clear)   crc <= '0;
    else if (step_en) crc <= crc_fold(crc, word);
  end

endmodule

// File: rtl/vid_lnum_crc_ins.sv
module vid_lnum_crc_ins
  import vid_lnum_crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din_valid,
  input  logic [WORD_W-1:0] din,
  input  logic [LINE_W-1:0] line_num,
  output logic              dout_valid,
  output logic [WORD_W-1:0] dout,
  output logic              ins_flag
);

  // named internal events, also observed by the bound checker
  logic             eav_hit;
  logic             sav_hit;
  slot_e            slot_q;
  slot_e            slot_d;
  logic             acc_q;
  logic [LINE_W-1:0] ln_q;
  logic [CRC_W-1:0] crc_q;
  logic [WORD_W-1:0] word_sel;
  logic             crc_step;
  logic             crc_clear;

  vid_lnum_crc_trs_watch u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (din_valid),
    .word    (din),
    .eav_hit (eav_hit),
    .sav_hit (sav_hit)
  );

  always_comb begin
    unique case (slot_q)
      SLOT_LN0:  word_sel = line_word_lo(ln_q);
      SLOT_LN1:  word_sel = line_word_hi(ln_q);
      SLOT_CRC0: word_sel = crc_word_lo(crc_q);
      SLOT_CRC1: word_sel = crc_word_hi(crc_q);
      default:   word_sel = din;
    endcase
  end

  always_comb begin
    slot_d = slot_q;
    if (eav_hit) begin
      slot_d = SLOT_LN0;
    end else if (din_valid) begin
      unique case (slot_q)
        SLOT_LN0:  slot_d = SLOT_LN1;
        SLOT_LN1:  slot_d = SLOT_CRC0;
        SLOT_CRC0: slot_d = SLOT_CRC1;
        default:   slot_d = SLOT_NONE;
      endcase
    end
  end

  assign crc_clear = din_valid && (slot_q == SLOT_CRC1);
  assign crc_step  = din_valid && acc_q &&
                     (slot_q == SLOT_NONE || slot_q == SLOT_LN0 || slot_q == SLOT_LN1);

  vid_lnum_crc_acc u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (crc_step),
    .clear   (crc_clear),
    .word    (word_sel),
    .crc     (crc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q     <= SLOT_NONE;
      acc_q      <= 1'b0;
      ln_q       <= '0;
      dout_valid <= 1'b0;
      dout       <= '0;
      ins_flag   <= 1'b0;
    end else begin
      slot_q     <= slot_d;
      dout_valid <= din_valid;
      ins_flag   <= din_valid && (slot_q != SLOT_NONE);
      if (din_valid) dout <= word_sel;
      if (eav_hit) ln_q <= line_num;
      if (crc_clear)    acc_q <= 1'b0;
      else if (sav_hit) acc_q <= 1'b1;
    end
  end

endmodule

// File: rtl/vid_lnum_crc_ins_chk.sv
module vid_lnum_crc_ins_chk
  import vid_lnum_crc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              din_valid,
  input logic              dout_valid,
  input logic [WORD_W-1:0] dout,
  input logic              ins_flag,
  input logic              eav_hit,
  input slot_e             slot_q,
  input logic [CRC_W-1:0]  crc_q
);

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    din_valid |=> dout_valid);

  assert_idle_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !din_valid |=> !dout_valid);

  assert_flag_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_flag |-> dout_valid);

  assert_slot_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && slot_q != SLOT_NONE) |=> ins_flag);

  assert_eav_next_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eav_hit && slot_q == SLOT_NONE) |=> !ins_flag);

  // covers R6 and R7: every inserted word has bit 9 opposite to bit 8
  assert_ins_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ins_flag |-> (dout[9] != dout[8]));

  assert_crc_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && slot_q == SLOT_CRC1) |=> (crc_q == '0));

endmodule

bind vid_lnum_crc_ins vid_lnum_crc_ins_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .din_valid  (din_valid),
  .dout_valid (dout_valid),
  .dout       (dout),
  .ins_flag   (ins_flag),
  .eav_hit    (eav_hit),
  .slot_q     (slot_q),
  .crc_q      (crc_q)
);

// File: tb/vid_lnum_crc_ins_tb.sv
module vid_lnum_crc_ins_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        din_valid = 1'b0;
  logic [9:0]  din = '0;
  logic [10:0] line_num = '0;
  logic        dout_valid;
  logic [9:0]  dout;
  logic        ins_flag;

  int errors = 0;
  int checks = 0;
  int flags_seen = 0;

  // bench model state
  logic [9:0]  bh0 = '0, bh1 = '0, bh2 = '0;
  int          bslot = 0;
  bit          bacc = 1'b0;
  logic [17:0] br = '0;
  logic [10:0] bln = '0;
  logic [10:0] cur_ln = '0;
  logic [9:0]  cap0 = '0, cap1 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_lnum_crc_ins u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .din_valid  (din_valid),
    .din        (din),
    .line_num   (line_num),
    .dout_valid (dout_valid),
    .dout       (dout),
    .ins_flag   (ins_flag)
  );

  // checksum in non-reflected orientation, bit-reversed at the end
  function automatic logic [17:0] ref_step(input logic [17:0] r, input logic [9:0] w);
    logic [17:0] t;
    logic fb;
    t = r;
    for (int i = 0; i < 10; i++) begin
      fb = t[17] ^ w[i];
      t  = {t[16:0], 1'b0};
      if (fb) t = t ^ 18'h00031;
    end
    return t;
  endfunction

  function automatic logic [17:0] rev18(input logic [17:0] r);
    logic [17:0] o;
    for (int i = 0; i < 18; i++) o[i] = r[17-i];
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic v, input logic [9:0] w, input logic [10:0] lnv);
    logic [9:0]  exp_w;
    bit          exp_f;
    string       tag;
    logic [17:0] c;
    bit          trs;
    @(negedge clk);
    din_valid = v;
    din       = w;
    line_num  = lnv;
    exp_w = w;
    exp_f = 1'b0;
    tag   = "R3 R4 passthrough";
    if (v) begin
      c = rev18(br);
      case (bslot)
        1: begin exp_w = {~bln[6], bln[6:0], 2'b00}; tag = "R6 line word 0"; end
        2: begin exp_w = {1'b1, 3'b000, bln[10:7], 2'b00}; tag = "R6 line word 1"; end
        3: begin exp_w = {~c[8], c[8:0]}; tag = "R7 R8 checksum word 0"; end
        4: begin exp_w = {~c[17], c[17:9]}; tag = "R7 R8 checksum word 1"; end
        default: ;
      endcase
      exp_f = (bslot != 0);
      trs = (bh0 == 10'h3FF) && (bh1 == 10'h000) && (bh2 == 10'h000);
      if (bslot == 4) begin br = '0; bacc = 1'b0; end
      else if (bacc && bslot != 3) br = ref_step(br, exp_w);
      if (trs && w[6]) begin bslot = 1; bln = lnv; end
      else if (bslot != 0) bslot = (bslot == 4) ? 0 : bslot + 1;
      if (trs && !w[6]) bacc = 1'b1;
      bh0 = bh1; bh1 = bh2; bh2 = w;
    end
    @(posedge clk);
    #1;
    chk(dout_valid == v, "R2 dout_valid", {9'd0, dout_valid}, {9'd0, v});
    if (v) begin
      chk(ins_flag == exp_f, "R5 ins_flag", {9'd0, ins_flag}, {9'd0, exp_f});
      chk(dout == exp_w, tag, dout, exp_w);
      if (ins_flag) flags_seen++;
      if (bslot == 0 && exp_f) cap1 = dout;
      if (bslot == 4) cap0 = dout;
    end else begin
      chk(ins_flag == 1'b0, "R2 idle flag", {9'd0, ins_flag}, 10'd0);
    end
  endtask

  // valid word, with an occasional idle cycle in front when gaps enabled
  task automatic put(input logic [9:0] w, input logic [10:0] lnv, input bit gaps);
    if (gaps && ($urandom % 8 == 0)) push(1'b0, 10'($urandom), lnv);
    push(1'b1, w, lnv);
  endtask

  task automatic send_line(input int n_act, input int n_blank, input logic [10:0] ln,
                           input bit gaps, input int unsigned dseed);
    int unsigned s;
    s = dseed;
    put(10'h3FF, ln, gaps); put(10'h000, ln, gaps); put(10'h000, ln, gaps);
    put(10'h200, ln, gaps);                          // start-of-active, bit 6 = 0
    for (int i = 0; i < n_act; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      put(10'(4 + (s >> 8) % 1016), ln, gaps);
    end
    put(10'h3FF, ln, gaps); put(10'h000, ln, gaps); put(10'h000, ln, gaps);
    put(10'h274, ln, gaps);                          // end-of-active, bit 6 = 1
    for (int i = 0; i < 4; i++) put(10'h040, 11'($urandom), gaps);
    for (int i = 0; i < n_blank; i++) put((i % 2) ? 10'h040 : 10'h200, ln, gaps);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [9:0] a0, a1;
    int fbefore;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1;
    chk(dout == 10'd0, "R1 reset dout", dout, 10'd0);
    chk(dout_valid == 1'b0, "R1 reset dout_valid", {9'd0, dout_valid}, 10'd0);
    chk(ins_flag == 1'b0, "R1 reset ins_flag", {9'd0, ins_flag}, 10'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: identical line twice, separated by unrelated traffic
    send_line(12, 6, 11'd42, 1'b0, 32'd777);
    a0 = cap0; a1 = cap1;
    send_line(20, 9, 11'd1125, 1'b1, 32'd99);
    for (int i = 0; i < 7; i++) put(10'($urandom % 1016 + 4), 11'd0, 1'b0);
    send_line(12, 6, 11'd42, 1'b0, 32'd777);
    chk(cap0 == a0, "R8 repeat checksum word 0", cap0, a0);
    chk(cap1 == a1, "R8 repeat checksum word 1", cap1, a1);

    // R4: broken preamble before an end-of-active style word
    fbefore = flags_seen;
    put(10'h3FF, 11'd5, 1'b0); put(10'h000, 11'd5, 1'b0); put(10'h001, 11'd5, 1'b0);
    put(10'h274, 11'd5, 1'b0);
    for (int i = 0; i < 4; i++) put(10'h040, 11'd5, 1'b0);
    chk(flags_seen == fbefore, "R4 broken preamble inserts", 10'(flags_seen - fbefore), 10'd0);

    // R4: start-of-active code alone inserts nothing
    fbefore = flags_seen;
    put(10'h3FF, 11'd6, 1'b0); put(10'h000, 11'd6, 1'b0); put(10'h000, 11'd6, 1'b0);
    put(10'h2AC, 11'd6, 1'b0);
    for (int i = 0; i < 5; i++) put(10'h100, 11'd6, 1'b0);
    chk(flags_seen == fbefore, "R4 start code inserts", 10'(flags_seen - fbefore), 10'd0);

    // R5 R2: end-of-active with idle gaps inside the sequence still yields four slots
    fbefore = flags_seen;
    send_line(5, 3, 11'h7FF, 1'b1, 32'd5);
    chk(flags_seen - fbefore == 4, "R5 four inserted words", 10'(flags_seen - fbefore), 10'd4);

    // R6 extremes of the line number, then random lines
    send_line(8, 2, 11'd0, 1'b0, 32'd11);
    send_line(8, 2, 11'h400, 1'b0, 32'd12);
    for (int n = 0; n < 25; n++) begin
      send_line(int'($urandom % 40) + 1, int'($urandom % 12), 11'($urandom), 1'b1, $urandom);
    end
    push(1'b0, 10'd0, 11'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule